// File: doc/BRIEF.md
# Multi-Slope Integrating ADC Conversion Sequencer

This block is the digital half of a multi-slope integrating analog-to-digital converter. It runs from the oscillator clock, derives a slower count tick, and walks the analog front end through a fixed schedule. The schedule is an auto-zero interval, a signal integration of fixed length, and then a de-integration. The de-integration first removes charge quickly with a coarse reference, then finishes with a fine reference. When the input lies beyond full scale it continues through up to three extra fine slots. Each interval is driven through one bit of a one-hot switch vector. The analog integrator's comparator comes back on a single input and is synchronised before use.

Each de-integrate slot ends early once the synchronised comparator departs from the level it held when the slot opened. The sequencer then leaves all switches open for the rest of that slot, so every conversion has the same length. The coarse and fine counts are packed into a binary result. The overrange count and the number of overrange slots that were actually driven are reported alongside it. A one-clock done strobe marks each finished conversion, and conversions follow one another for as long as `run` stays high.

Top module: `intadc_seq`

## Requirements
- R1: All phase timing advances on an internal tick that occurs once every DIV (default 4) clocks; two ticks are never on adjacent clocks.
- R2: A conversion opens with an auto-zero phase of ZERO_LEN (246) ticks in which only sw[0] (auto-zero, input disconnected) is high.
- R3: The signal phase follows for exactly SIG_LEN (256) ticks with only sw[1] (input connected) high.
- R4: The coarse slot drives sw[2] for at most FAST_LEN (512) ticks. A comparator change first seen at slot tick k (counted from 0) ends the drive after tick k and gives a coarse count of k. A slot that runs out gives FAST_LEN-1. sw[2] only rises straight after sw[1].
- R5: After SETTLE_LEN (2) idle ticks the fine slot drives sw[3] for at most SLOW_LEN (64) ticks, with the same early-end rule and a count of k, or SLOW_LEN-1 when it runs out.
- R6: The overrange slots (sw[4]) are driven only if the fine slot ran out with no comparator change. Each driven slot lasts up to OVR_LEN (64) ticks, and a slot is driven only if the slot before it also ran out. ovr_used gives the number of driven slots (0 to 3). ovr_cnt gives the number of overrange ticks before the change, or 192 if none is seen. Both are 0 when no slot was driven.
- R7: Every conversion occupies 1280 ticks (5120 clocks by default) from done strobe to done strobe, and the reference part is always 778 ticks: 512 + 64 + 3x64 + 5 settle slots of 2 ticks.
- R8: result = coarse count x SLOW_LEN + fine count, 15 bits. It changes only on the clock edge that raises done.
- R9: cmp_in passes through two flip-flops. A change applied at least two clocks before a tick edge is acted on at that tick.
- R10: done is high for one clock per conversion. While run is high a new conversion starts at once. While run is low the sequencer rests in auto-zero with sw = 5'b00001 and raises no done.
- R11: A synchronous active-low reset returns the sequencer to the start of auto-zero, with sw = 5'b00001, done low and all result outputs zero.
- R12: sw is never more than one-hot. During settle slots, and after a slot has ended early, sw is all zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Oscillator clock |
| rst_n | input | 1 | Synchronous active-low reset |
| run | input | 1 | Allows conversions to start and repeat |
| cmp_in | input | 1 | Asynchronous comparator level from the integrator |
| sw | output | 5 | One-hot switch controls: 0 auto-zero, 1 signal, 2 coarse ref, 3 fine ref, 4 overrange ref |
| result | output | 15 | Coarse count x 64 + fine count |
| ovr_used | output | 2 | Number of overrange slots driven |
| ovr_cnt | output | 8 | Overrange ticks before the comparator change |
| done | output | 1 | One-clock strobe at the end of each conversion |

## Verification
The bench builds the block with its default parameters: a divide-by-4 tick, the full 512-tick coarse slot and the three 64-tick overrange slots. This puts the true boundaries within reach: a change on the first and the last tick of a slot, coarse and fine slots that run out, and overrange changes in each of the three slots, as well as none at all. A behavioural comparator flips its level at chosen ticks, timed from the rising edge of each switch output. It then checks the packed result, the length of each driven switch, the number of overrange pulses and the fixed conversion period.

// File: rtl/intadc_pkg.sv
// Shared definitions for the integrating ADC sequencer.
// Assumes: switch vector bit order is fixed and decoded by the analog front end.
package intadc_pkg;
    typedef enum logic [2:0] {
        PH_ZERO  = 3'd0,
        PH_SIG   = 3'd1,
        PH_FAST  = 3'd2,
        PH_SET1  = 3'd3,
        PH_SLOW  = 3'd4,
        PH_SET2  = 3'd5,
        PH_OVR   = 3'd6,
        PH_SET3  = 3'd7
    } phase_e;

    localparam int SW_AZ   = 0;
    localparam int SW_SIG  = 1;
    localparam int SW_FAST = 2;
    localparam int SW_SLOW = 3;
    localparam int SW_OVR  = 4;
    localparam int SW_N    = 5;
endpackage

// File: rtl/intadc_tick_div.sv
// Divides the oscillator clock into a one-clock tick enable every DIV clocks.
// Assumes: DIV >= 2; the counter restarts from zero on reset.
module intadc_tick_div #(
    parameter int DIV = 4
) (
    input  logic clk,
    input  logic rst_n,
    output logic tick
);
    localparam int CW = $clog2(DIV);

    logic [CW-1:0] cnt;

    // Free-running modulo-DIV counter.
    always_ff @(posedge clk) begin
        if (!rst_n)                    cnt <= '0;
        else if (cnt == CW'(DIV - 1))  cnt <= '0;
        else                           cnt <= cnt + 1'b1;
    end

    // Tick on the last count of each period.
    always_comb tick = (cnt == CW'(DIV - 1));
endmodule

// File: rtl/intadc_sync2.sv
// Two-stage synchroniser for the asynchronous comparator level.
// Assumes: input changes are slow relative to the clock.
module intadc_sync2 (
    input  logic clk,
    input  logic rst_n,
    input  logic d_async,
    output logic q_sync
);
    logic meta;

    // Shift the level through two flops.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta   <= 1'b0;
            q_sync <= 1'b0;
        end else begin
            meta   <= d_async;
            q_sync <= meta;
        end
    end
endmodule

// File: rtl/intadc_phase_ctl.sv
// Phase state machine: walks auto-zero, signal, coarse, fine and overrange
// slots with settle gaps, ending each de-integrate slot early on a comparator
// change while keeping every slot its full length.
// Assumes: tick is a one-clock enable; cmp_s is already synchronised.
module intadc_phase_ctl
    import intadc_pkg::*;
#(
    parameter int ZERO_LEN   = 246,
    parameter int SIG_LEN    = 256,
    parameter int FAST_LEN   = 512,
    parameter int SLOW_LEN   = 64,
    parameter int OVR_LEN    = 64,
    parameter int OVR_SLOTS  = 3,
    parameter int SETTLE_LEN = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              run,
    input  logic              cmp_s,
    output logic [SW_N-1:0]   sw,
    output logic              inc_fast,
    output logic              inc_slow,
    output logic              inc_ovr,
    output logic              ovr_go,
    output logic              conv_end
);
    localparam int M1      = (ZERO_LEN > SIG_LEN) ? ZERO_LEN : SIG_LEN;
    localparam int M2      = (M1 > FAST_LEN) ? M1 : FAST_LEN;
    localparam int M3      = (M2 > SLOW_LEN) ? M2 : SLOW_LEN;
    localparam int M4      = (M3 > OVR_LEN) ? M3 : OVR_LEN;
    localparam int MAX_LEN = (M4 > SETTLE_LEN) ? M4 : SETTLE_LEN;
    localparam int SLOT_W  = $clog2(MAX_LEN);
    localparam int IDX_W   = (OVR_SLOTS > 1) ? $clog2(OVR_SLOTS) : 1;

    phase_e             ph;
    logic [SLOT_W-1:0]  k;
    logic [SLOT_W-1:0]  len_m1;
    logic [IDX_W-1:0]   oidx;
    logic               act;
    logic               pol;
    logic               carry;
    logic               last;
    logic               hold;
    logic               nf;
    logic               last_ovr;

    // Last slot index of the current phase.
    always_comb begin
        unique case (ph)
            PH_ZERO: len_m1 = SLOT_W'(ZERO_LEN - 1);
            PH_SIG:  len_m1 = SLOT_W'(SIG_LEN - 1);
            PH_FAST: len_m1 = SLOT_W'(FAST_LEN - 1);
            PH_SLOW: len_m1 = SLOT_W'(SLOW_LEN - 1);
            PH_OVR:  len_m1 = SLOT_W'(OVR_LEN - 1);
            default: len_m1 = SLOT_W'(SETTLE_LEN - 1);
        endcase
    end

    // Slot end, run gating, and "still driving with no comparator change".
    always_comb begin
        last     = (k == len_m1);
        hold     = (ph == PH_ZERO) && !run;
        nf       = act && (cmp_s == pol);
        last_ovr = (oidx == IDX_W'(OVR_SLOTS - 1));
    end

    // Phase sequencing, slot counting and drive/polarity tracking.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ph    <= PH_ZERO;
            k     <= '0;
            oidx  <= '0;
            act   <= 1'b0;
            pol   <= 1'b0;
            carry <= 1'b0;
        end else if (tick) begin
            if (hold) begin
                k <= '0;
            end else if (last) begin
                k <= '0;
                unique case (ph)
                    PH_ZERO: ph <= PH_SIG;
                    PH_SIG: begin
                        ph  <= PH_FAST;
                        act <= 1'b1;
                        pol <= cmp_s;
                    end
                    PH_FAST: begin
                        ph  <= PH_SET1;
                        act <= 1'b0;
                    end
                    PH_SET1: begin
                        ph  <= PH_SLOW;
                        act <= 1'b1;
                        pol <= cmp_s;
                    end
                    PH_SLOW, PH_OVR: begin
                        ph    <= (ph == PH_SLOW) ? PH_SET2 : PH_SET3;
                        carry <= nf;
                        act   <= 1'b0;
                    end
                    PH_SET2: begin
                        ph   <= PH_OVR;
                        oidx <= '0;
                        act  <= carry;
                        pol  <= cmp_s;
                    end
                    default: begin
                        if (last_ovr) begin
                            ph <= PH_ZERO;
                        end else begin
                            ph   <= PH_OVR;
                            oidx <= oidx + 1'b1;
                            act  <= carry;
                            pol  <= cmp_s;
                        end
                    end
                endcase
            end else begin
                k <= k + 1'b1;
                if (act && (cmp_s != pol)) act <= 1'b0;
            end
        end
    end

    // One-hot switch drive from phase and drive flag.
    always_comb begin
        sw          = '0;
        sw[SW_AZ]   = (ph == PH_ZERO);
        sw[SW_SIG]  = (ph == PH_SIG);
        sw[SW_FAST] = (ph == PH_FAST) && act;
        sw[SW_SLOW] = (ph == PH_SLOW) && act;
        sw[SW_OVR]  = (ph == PH_OVR)  && act;
    end

    // Count and boundary events for the result assembler.
    always_comb begin
        inc_fast = tick && (ph == PH_FAST) && nf && !last;
        inc_slow = tick && (ph == PH_SLOW) && nf && !last;
        inc_ovr  = tick && (ph == PH_OVR)  && nf;
        ovr_go   = tick && last && carry &&
                   ((ph == PH_SET2) || ((ph == PH_SET3) && !last_ovr));
        conv_end = tick && last && (ph == PH_SET3) && last_ovr;
    end
endmodule

// File: rtl/intadc_result.sv
// Accumulates coarse, fine and overrange counts and publishes them with a
// one-clock done strobe at the end of each conversion.
// Assumes: SLOW_LEN is a power of two so packing equals coarse*SLOW_LEN+fine.
module intadc_result #(
    parameter int FAST_W = 9,
    parameter int SLOW_W = 6,
    parameter int OVR_W  = 8,
    parameter int USE_W  = 2
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     inc_fast,
    input  logic                     inc_slow,
    input  logic                     inc_ovr,
    input  logic                     ovr_go,
    input  logic                     conv_end,
    output logic [FAST_W+SLOW_W-1:0] result,
    output logic [USE_W-1:0]         ovr_used,
    output logic [OVR_W-1:0]         ovr_cnt,
    output logic                     done
);
    logic [FAST_W-1:0] fast_acc;
    logic [SLOW_W-1:0] slow_acc;
    logic [OVR_W-1:0]  ovr_acc;
    logic [USE_W-1:0]  use_acc;

    // Running counts, cleared as each conversion is published.
    always_ff @(posedge clk) begin
        if (!rst_n || conv_end) begin
            fast_acc <= '0;
            slow_acc <= '0;
            ovr_acc  <= '0;
            use_acc  <= '0;
        end else begin
            if (inc_fast) fast_acc <= fast_acc + 1'b1;
            if (inc_slow) slow_acc <= slow_acc + 1'b1;
            if (inc_ovr)  ovr_acc  <= ovr_acc + 1'b1;
            if (ovr_go)   use_acc  <= use_acc + 1'b1;
        end
    end

    // Published outputs and done strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            result   <= '0;
            ovr_used <= '0;
            ovr_cnt  <= '0;
            done     <= 1'b0;
        end else begin
            done <= conv_end;
            if (conv_end) begin
                result   <= {fast_acc, slow_acc};
                ovr_used <= use_acc;
                ovr_cnt  <= ovr_acc;
            end
        end
    end
endmodule

// File: rtl/intadc_seq.sv
// Top of the integrating ADC sequencer: tick divider, comparator
// synchroniser, phase state machine and result assembly.
// Assumes: analog switches, integrator and comparator sit outside this block.
module intadc_seq
    import intadc_pkg::*;
#(
    parameter int DIV        = 4,
    parameter int ZERO_LEN   = 246,
    parameter int SIG_LEN    = 256,
    parameter int FAST_LEN   = 512,
    parameter int SLOW_LEN   = 64,
    parameter int OVR_LEN    = 64,
    parameter int OVR_SLOTS  = 3,
    parameter int SETTLE_LEN = 2,
    localparam int FAST_W    = $clog2(FAST_LEN),
    localparam int SLOW_W    = $clog2(SLOW_LEN),
    localparam int RES_W     = FAST_W + SLOW_W,
    localparam int OVR_W     = $clog2(OVR_LEN * OVR_SLOTS + 1),
    localparam int USE_W     = $clog2(OVR_SLOTS + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run,
    input  logic              cmp_in,
    output logic [SW_N-1:0]   sw,
    output logic [RES_W-1:0]  result,
    output logic [USE_W-1:0]  ovr_used,
    output logic [OVR_W-1:0]  ovr_cnt,
    output logic              done
);
    logic tick;
    logic cmp_s;
    logic inc_fast, inc_slow, inc_ovr, ovr_go, conv_end;

    intadc_tick_div #(.DIV(DIV)) u_div (
        .clk  (clk),
        .rst_n(rst_n),
        .tick (tick)
    );

    intadc_sync2 u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .d_async(cmp_in),
        .q_sync (cmp_s)
    );

    intadc_phase_ctl #(
        .ZERO_LEN  (ZERO_LEN),
        .SIG_LEN   (SIG_LEN),
        .FAST_LEN  (FAST_LEN),
        .SLOW_LEN  (SLOW_LEN),
        .OVR_LEN   (OVR_LEN),
        .OVR_SLOTS (OVR_SLOTS),
        .SETTLE_LEN(SETTLE_LEN)
    ) u_ctl (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick    (tick),
        .run     (run),
        .cmp_s   (cmp_s),
        .sw      (sw),
        .inc_fast(inc_fast),
        .inc_slow(inc_slow),
        .inc_ovr (inc_ovr),
        .ovr_go  (ovr_go),
        .conv_end(conv_end)
    );

    intadc_result #(
        .FAST_W(FAST_W),
        .SLOW_W(SLOW_W),
        .OVR_W (OVR_W),
        .USE_W (USE_W)
    ) u_res (
        .clk     (clk),
        .rst_n   (rst_n),
        .inc_fast(inc_fast),
        .inc_slow(inc_slow),
        .inc_ovr (inc_ovr),
        .ovr_go  (ovr_go),
        .conv_end(conv_end),
        .result  (result),
        .ovr_used(ovr_used),
        .ovr_cnt (ovr_cnt),
        .done    (done)
    );
endmodule

// File: rtl/intadc_seq_chk.sv
// Property checker for the sequencer, bound to the top module.
// Assumes: reset is asserted from time zero.
module intadc_seq_chk #(
    parameter int SW_N      = 5,
    parameter int RES_W     = 15,
    parameter int SLOW_W    = 6,
    parameter int USE_W     = 2,
    parameter int OVR_W     = 8,
    parameter int SLOW_LEN  = 64,
    parameter int OVR_TOTAL = 192
) (
    input logic             clk,
    input logic             rst_n,
    input logic             tick,
    input logic [SW_N-1:0]  sw,
    input logic [RES_W-1:0] result,
    input logic [USE_W-1:0] ovr_used,
    input logic [OVR_W-1:0] ovr_cnt,
    input logic             done
);
    a_r1_tick_gap: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> !tick);

    a_r12_sw_onehot: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(sw));

    a_r11_reset_safe: assert property (@(posedge clk)
        !rst_n |=> (sw == SW_N'(1)) && !done);

    a_r10_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    a_r4_fast_after_sig: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sw[2]) |-> $past(sw[1]));

    a_r6_ovr_needs_full_fine: assert property (@(posedge clk) disable iff (!rst_n)
        (ovr_used != '0) |-> (result[SLOW_W-1:0] == SLOW_W'(SLOW_LEN - 1)));

    a_r6_ovr_zero_unused: assert property (@(posedge clk) disable iff (!rst_n)
        (ovr_used == '0) |-> (ovr_cnt == '0));

    a_r6_ovr_bound: assert property (@(posedge clk) disable iff (!rst_n)
        ovr_cnt <= OVR_W'(OVR_TOTAL));

    a_r8_result_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !done |-> $stable(result));
endmodule

bind intadc_seq intadc_seq_chk #(
    .SW_N     (intadc_pkg::SW_N),
    .RES_W    (RES_W),
    .SLOW_W   (SLOW_W),
    .USE_W    (USE_W),
    .OVR_W    (OVR_W),
    .SLOW_LEN (SLOW_LEN),
    .OVR_TOTAL(OVR_LEN * OVR_SLOTS)
) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .tick    (tick),
    .sw      (sw),
    .result  (result),
    .ovr_used(ovr_used),
    .ovr_cnt (ovr_cnt),
    .done    (done)
);

// File: tb/intadc_seq_test.sv
// Bench for intadc_seq: a vector table of comparator change points walked by
// one loop, then directed reset and run-gating tests.
module intadc_seq_test;
    localparam int CLK_PERIOD = 10;
    localparam int NVEC       = 9;
    localparam int WATCHDOG   = 150000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        run = 1'b0;
    logic        cmp_in = 1'b0;
    logic [4:0]  sw;
    logic [14:0] result;
    logic [1:0]  ovr_used;
    logic [7:0]  ovr_cnt;
    logic        done;

    int checks = 0;
    int errors = 0;

    // {coarse change tick (512 = none), fine change tick (64 = none),
    //  overrange slot of change (0 = none), tick within that slot}
    localparam logic [24:0] VEC [NVEC] = '{
        {10'd100, 7'd20, 2'd0, 6'd0},
        {10'd0,   7'd0,  2'd0, 6'd0},
        {10'd511, 7'd63, 2'd0, 6'd0},
        {10'd512, 7'd5,  2'd0, 6'd0},
        {10'd300, 7'd64, 2'd1, 6'd10},
        {10'd7,   7'd64, 2'd2, 6'd0},
        {10'd7,   7'd64, 2'd3, 6'd63},
        {10'd1,   7'd64, 2'd0, 6'd0},
        {10'd255, 7'd33, 2'd0, 6'd0}
    };

    intadc_seq uut (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (run),
        .cmp_in  (cmp_in),
        .sw      (sw),
        .result  (result),
        .ovr_used(ovr_used),
        .ovr_cnt (ovr_cnt),
        .done    (done)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    // Per-conversion measurements taken at negedges, snapshotted on done.
    int c_az, c_sig, c_fast, c_slow, c_rise, c_per;
    int s_az, s_sig, s_fast, s_slow, s_rise, s_per;
    logic prev_ovr = 1'b0;
    always @(negedge clk) begin
        if (!rst_n) begin
            c_az = 0; c_sig = 0; c_fast = 0; c_slow = 0; c_rise = 0; c_per = 0;
        end else begin
            if (done) begin
                s_az = c_az; s_sig = c_sig; s_fast = c_fast;
                s_slow = c_slow; s_rise = c_rise; s_per = c_per;
                c_az = 0; c_sig = 0; c_fast = 0; c_slow = 0; c_rise = 0; c_per = 0;
            end
            c_per++;
            if (sw[0]) c_az++;
            if (sw[1]) c_sig++;
            if (sw[2]) c_fast++;
            if (sw[3]) c_slow++;
            if (sw[4] && !prev_ovr) c_rise++;
        end
        prev_ovr = sw[4];
    end

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic wait_hi(input int b);
        while (!sw[b]) @(negedge clk);
    endtask

    // Drive one conversion with given change points and check its outputs.
    task automatic run_conv(input logic [24:0] v, input bit chk_len);
        int ff, fs, oj, ok, e_f, e_s, e_use, e_ovr;
        ff = int'(v[24:15]); fs = int'(v[14:8]); oj = int'(v[7:6]); ok = int'(v[5:0]);
        e_f = (ff > 511) ? 511 : ff;
        e_s = (fs > 63) ? 63 : fs;
        if (fs < 64)      begin e_use = 0;  e_ovr = 0; end
        else if (oj == 0) begin e_use = 3;  e_ovr = 192; end
        else              begin e_use = oj; e_ovr = 64 * (oj - 1) + ok; end

        wait_hi(2);
        if (ff < 512) begin repeat (4 * ff) @(negedge clk); cmp_in = ~cmp_in; end
        wait_hi(3);
        if (fs < 64) begin repeat (4 * fs) @(negedge clk); cmp_in = ~cmp_in; end
        if (fs >= 64 && oj != 0) begin
            for (int j = 1; j <= oj; j++) begin
                wait_hi(4);
                if (j < oj) while (sw[4]) @(negedge clk);
            end
            repeat (4 * ok) @(negedge clk);
            cmp_in = ~cmp_in;
        end
        while (!done) @(negedge clk);
        check(result == 15'(e_f * 64 + e_s), "R8 result", int'(result), e_f * 64 + e_s);
        check(ovr_used == 2'(e_use), "R6 ovr_used", int'(ovr_used), e_use);
        check(ovr_cnt == 8'(e_ovr), "R6 ovr_cnt", int'(ovr_cnt), e_ovr);
        @(negedge clk);
        check(done == 1'b0, "R10 done one clock", int'(done), 0);
        check(s_fast == 4 * (e_f + 1), "R4 R9 coarse drive clocks", s_fast, 4 * (e_f + 1));
        check(s_slow == 4 * (e_s + 1), "R5 R9 fine drive clocks", s_slow, 4 * (e_s + 1));
        check(s_rise == e_use, "R6 R12 overrange pulses", s_rise, e_use);
        if (chk_len) begin
            check(s_az == 4 * 246, "R2 R1 auto-zero clocks", s_az, 984);
            check(s_sig == 4 * 256, "R3 signal clocks", s_sig, 1024);
            check(s_per == 4 * 1280, "R7 conversion clocks", s_per, 5120);
        end
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (WATCHDOG) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: actual %0d expected 0 (cycles exhausted)", WATCHDOG);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        int quiet;
        // R11: reset state.
        repeat (6) @(negedge clk);
        check(sw == 5'b00001, "R11 reset sw", int'(sw), 1);
        check(result == '0 && ovr_cnt == '0 && ovr_used == '0, "R11 reset outputs", int'(result), 0);
        check(done == 1'b0, "R11 reset done", int'(done), 0);
        rst_n = 1'b1;
        run   = 1'b1;

        // Vector table; the first conversion starts from reset and is not timed.
        for (int i = 0; i < NVEC; i++) run_conv(VEC[i], i != 0);

        // R10: run low keeps the sequencer resting in auto-zero.
        run = 1'b0;
        quiet = 0;
        for (int n = 0; n < 6000; n++) begin
            @(negedge clk);
            if (done || sw != 5'b00001) quiet++;
        end
        check(quiet == 0, "R10 idle while run low", quiet, 0);
        run = 1'b1;
        run_conv(VEC[0], 1'b0);

        // R11: reset during the coarse slot.
        wait_hi(2);
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        check(sw == 5'b00001, "R11 mid reset sw", int'(sw), 1);
        check(result == '0 && done == 1'b0, "R11 mid reset outputs", int'(result), 0);
        rst_n = 1'b1;
        run_conv(VEC[4], 1'b0);
        run_conv(VEC[2], 1'b1);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule